// File: doc/BRIEF.md
# UART Transmitter with Flow Gating

This block is the transmit half of a serial port. Bytes written into its transmit queue are sent out one at a time as 8N1 frames on a single serial line: one start bit, eight data bits with the least significant bit first, and one stop bit. Each bit lasts exactly one interval of an external bit-rate strobe. The block does not generate its own baud rate. It does not decode registers either; its control bits come in as plain input levels.

Three independent conditions can hold back queued data:
- a transmitter-disable control;
- a hold raised when the far end has sent XOFF;
- automatic gating by the active-low data-set-ready input, which is enabled separately.

None of these conditions stops the receive side from asking for an in-band XON or XOFF character. That character is sent at the next frame boundary even while data is held, and it goes ahead of any queued data. A frame that has started always runs to completion, so every gating change takes effect only between frames.

Status outputs report the number of bytes waiting in the queue, whether the shift register is empty, and whether the whole transmitter is idle.

Top module: `uart_tx_gate`

## Requirements
- R1: Every frame on `serial_out` is a 0 start bit, eight data bits sent least significant bit first, and a 1 stop bit. A frame begins only in a cycle where `baud_tick` is 1, and each bit holds for exactly one `baud_tick` interval.
- R2: Queued bytes are sent in the order they were written. A write while `fifo_full` is 1 is dropped. `fill_level` equals the number of bytes currently queued.
- R3: While `tx_disable` is 1, no queued byte starts a frame. A change of `tx_disable` during a frame leaves that frame intact and applies from the next frame boundary.
- R4: A one-cycle `flow_send` pulse queues one in-band character. It is 0x11 when `flow_kind` is 0 and 0x13 when `flow_kind` is 1. The character is sent even while data is held by `tx_disable`, `xoff_hold` or data-set-ready gating.
- R5: A pending flow character is sent at the next frame boundary ahead of any queued data byte.
- R6: While `xoff_hold` is 1, no queued byte starts a frame. Data resumes once it returns to 0.
- R7: When `dsr_flow_en` is 1, no queued byte starts a frame while `dsr_n` is 1. When `dsr_flow_en` is 0, `dsr_n` has no effect on transmission.
- R8: `serial_out` is 1 whenever no frame is in progress. `tx_empty` is 0 for the whole frame, stop bit included, and rises only after the stop bit interval ends.
- R9: `tx_idle` is 1 only when the queue is empty and no frame is in progress. It is 0 while a frame is being sent.
- R10: After a synchronous reset (`rst_n` low at a clock edge), `serial_out` is 1, `fill_level` is 0, and `tx_empty`, `tx_idle` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe marking each bit interval boundary |
| wr_en | input | 1 | Write a byte into the transmit queue |
| wr_data | input | 8 | Byte to queue |
| tx_disable | input | 1 | Hold queued data (applied at frame boundaries) |
| xoff_hold | input | 1 | Hold queued data after XOFF was received |
| dsr_flow_en | input | 1 | Enable automatic data-set-ready gating |
| dsr_n | input | 1 | Active-low data-set-ready line |
| flow_send | input | 1 | Pulse: request one in-band flow character |
| flow_kind | input | 1 | 0 = XON (0x11), 1 = XOFF (0x13) |
| serial_out | output | 1 | Serial line, idles high |
| fill_level | output | $clog2(FIFO_DEPTH+1) | Bytes waiting in the queue |
| fifo_full | output | 1 | Queue holds FIFO_DEPTH bytes |
| tx_empty | output | 1 | Shift register empty, no frame in progress |
| tx_idle | output | 1 | Queue and shift register both empty |

## Verification
The bench builds the block with an eight-entry queue and a bit strobe every fourth clock. The small queue lets a burst of ten writes reach the full condition and the dropped-write case in a few cycles. The short bit interval fits dozens of complete frames, including back-to-back ones, into a short run. The bench decodes the serial line itself, once per bit interval, and compares the received characters with a queue of expected bytes. This exposes ordering, priority and mid-frame gating changes directly as differences in the character stream.

// File: rtl/uart_tx_pkg.sv
// Package: shared constants and types for the gated UART transmitter.
// Assumes 8-bit characters and fixed XON/XOFF codes.
package uart_tx_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] XON_CODE  = 8'h11;
    localparam logic [BYTE_W-1:0] XOFF_CODE = 8'h13;

    typedef enum logic {
        FLOW_XON  = 1'b0,
        FLOW_XOFF = 1'b1
    } flow_kind_e;
endpackage

// File: rtl/tx_byte_fifo.sv
// Module: synchronous byte queue with an exact occupancy count.
// Assumes DEPTH >= 2. A push into a full queue is dropped, even when a
// pop happens in the same cycle. A pop of an empty queue is ignored.
module tx_byte_fifo #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            push,
    input  logic [uart_tx_pkg::BYTE_W-1:0]  din,
    input  logic                            pop,
    output logic [uart_tx_pkg::BYTE_W-1:0]  dout,
    output logic                            full,
    output logic                            empty,
    output logic [CW-1:0]                   count
);
    import uart_tx_pkg::*;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write; entries need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and count upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R2
    drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/tx_frame_shifter.sv
// Module: shifts one 8N1 frame per load, one bit per baud_tick interval.
// Assumes load is only raised in a cycle where baud_tick is 1 and the shifter
// is either empty or finishing its stop bit (frame boundary).
module tx_frame_shifter (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick,
    input  logic                            load,
    input  logic [uart_tx_pkg::BYTE_W-1:0]  load_data,
    output logic                            busy,
    output logic                            frame_end,
    output logic                            bit_out
);
    import uart_tx_pkg::*;

    localparam int FRAME_BITS = BYTE_W + 2;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      bit_cnt;

    assign frame_end = tick && busy && (bit_cnt == LAST_BIT);
    assign bit_out   = busy ? shreg[0] : 1'b1;

    // Frame load, bit advance and end-of-frame release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '1;
            bit_cnt <= '0;
            busy    <= 1'b0;
        end else if (tick) begin
            if (load) begin
                shreg   <= {1'b1, load_data, 1'b0};
                bit_cnt <= '0;
                busy    <= 1'b1;
            end else if (busy) begin
                if (bit_cnt == LAST_BIT) begin
                    busy <= 1'b0;
                end else begin
                    shreg   <= {1'b1, shreg[FRAME_BITS-1:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R1
    load_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (tick && (!busy || frame_end)));
    // R1
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(bit_out));
    // R8
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> bit_out);
endmodule

// File: rtl/tx_flow_arbiter.sv
// Module: picks what the next frame carries at each frame boundary.
// A pending flow character wins. Otherwise the head byte is taken only when
// no hold applies. Assumes flow_send is a one-cycle pulse; a new pulse while
// one is still pending replaces its kind.
module tx_flow_arbiter (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            boundary,
    input  logic                            fifo_empty,
    input  logic [uart_tx_pkg::BYTE_W-1:0]  fifo_head,
    input  logic                            tx_disable,
    input  logic                            xoff_hold,
    input  logic                            dsr_flow_en,
    input  logic                            dsr_n,
    input  logic                            flow_send,
    input  logic                            flow_kind,
    output logic                            load,
    output logic [uart_tx_pkg::BYTE_W-1:0]  load_data,
    output logic                            pop
);
    import uart_tx_pkg::*;

    logic       pend;
    flow_kind_e pend_kind;
    logic       data_hold;
    logic       take_flow;

    assign data_hold = tx_disable || xoff_hold || (dsr_flow_en && dsr_n);
    assign take_flow = boundary && pend;
    assign pop       = boundary && !pend && !fifo_empty && !data_hold;
    assign load      = take_flow || pop;

    // Payload select: flow character or the queue head.
    always_comb begin
        if (pend) load_data = (pend_kind == FLOW_XOFF) ? XOFF_CODE : XON_CODE;
        else      load_data = fifo_head;
    end

    // Flow request latch, cleared when its frame is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_kind <= FLOW_XON;
        end else if (flow_send) begin
            pend      <= 1'b1;
            pend_kind <= flow_kind_e'(flow_kind);
        end else if (take_flow) begin
            pend <= 1'b0;
        end
    end

    // R3
    disable_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !tx_disable);
    // R6
    xoff_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !xoff_hold);
    // R7
    dsr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !(dsr_flow_en && dsr_n));
    // R5
    flow_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && pend) |-> (load && !pop));
endmodule

// File: rtl/uart_tx_gate.sv
// Module: top of the gated UART transmitter: queue, arbiter and shifter.
// Assumes baud_tick is a one-cycle strobe per bit interval from an external
// rate generator. Control inputs are levels sampled at frame boundaries.
module uart_tx_gate #(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             tx_disable,
    input  logic             xoff_hold,
    input  logic             dsr_flow_en,
    input  logic             dsr_n,
    input  logic             flow_send,
    input  logic             flow_kind,
    output logic             serial_out,
    output logic [LVL_W-1:0] fill_level,
    output logic             fifo_full,
    output logic             tx_empty,
    output logic             tx_idle
);
    import uart_tx_pkg::*;

    logic              fifo_empty, fifo_pop;
    logic [BYTE_W-1:0] fifo_head, load_data;
    logic              sh_busy, sh_end, sh_load, boundary;

    tx_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en),
        .din   (wr_data),
        .pop   (fifo_pop),
        .dout  (fifo_head),
        .full  (fifo_full),
        .empty (fifo_empty),
        .count (fill_level)
    );

    assign boundary = baud_tick && (!sh_busy || sh_end);

    tx_flow_arbiter u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary    (boundary),
        .fifo_empty  (fifo_empty),
        .fifo_head   (fifo_head),
        .tx_disable  (tx_disable),
        .xoff_hold   (xoff_hold),
        .dsr_flow_en (dsr_flow_en),
        .dsr_n       (dsr_n),
        .flow_send   (flow_send),
        .flow_kind   (flow_kind),
        .load        (sh_load),
        .load_data   (load_data),
        .pop         (fifo_pop)
    );

    tx_frame_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .load      (sh_load),
        .load_data (load_data),
        .busy      (sh_busy),
        .frame_end (sh_end),
        .bit_out   (serial_out)
    );

    assign tx_empty = !sh_busy;
    assign tx_idle  = !sh_busy && fifo_empty;

    // R9
    idle_means_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> (fill_level == '0 && serial_out));
    // R8
    empty_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> $past(sh_end));
endmodule

// File: tb/sim_uart_tx_gate.sv
module sim_uart_tx_gate;
    localparam int DEPTH = 8;
    localparam int DIV   = 4;
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 0;
    logic rst_n = 0;
    logic baud_tick = 0;
    logic wr_en = 0;
    logic [7:0] wr_data = 0;
    logic tx_disable = 0, xoff_hold = 0, dsr_flow_en = 0, dsr_n = 0;
    logic flow_send = 0, flow_kind = 0;
    logic serial_out, fifo_full, tx_empty, tx_idle;
    logic [LW-1:0] fill_level;

    int checks = 0;
    int errors = 0;
    logic [7:0] rxq[$];
    logic [7:0] expq[$];

    always #5 clk = ~clk;

    uart_tx_gate #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .tx_disable(tx_disable), .xoff_hold(xoff_hold),
        .dsr_flow_en(dsr_flow_en), .dsr_n(dsr_n), .flow_send(flow_send),
        .flow_kind(flow_kind), .serial_out(serial_out), .fill_level(fill_level),
        .fifo_full(fifo_full), .tx_empty(tx_empty), .tx_idle(tx_idle)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] flow_code(input logic kind);
        return kind ? 8'h13 : 8'h11;
    endfunction

    // Bit strobe and serial-line decoder share one process to fix their order.
    int tcnt = 0;
    bit in_frame = 0;
    int bitn = 0;
    logic [7:0] sh = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            tcnt = 0; baud_tick = 0; in_frame = 0;
        end else begin
            if (baud_tick) begin
                if (!in_frame) begin
                    if (serial_out == 1'b0) begin in_frame = 1; bitn = 0; end
                end else if (bitn < 8) begin
                    sh[bitn] = serial_out; bitn++;
                end else begin
                    // R1 stop bit, R8 empty still low during stop
                    check(serial_out === 1'b1, "R1 stop bit", serial_out, 1);
                    check(tx_empty === 1'b0, "R8 empty during stop", tx_empty, 0);
                    rxq.push_back(sh);
                    in_frame = 0;
                end
            end
            tcnt = (tcnt + 1) % DIV;
            baud_tick = (tcnt == 0);
        end
    end

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1; wr_data = b;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pulse_flow(input logic kind);
        @(negedge clk);
        flow_send = 1; flow_kind = kind;
        @(negedge clk);
        flow_send = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_start;
        do @(negedge clk); while (serial_out !== 1'b0);
    endtask

    task automatic expect_rx(input logic [7:0] exp, input string req);
        if (rxq.size() == 0) check(0, req, -1, exp);
        else begin
            logic [7:0] got;
            got = rxq.pop_front();
            check(got === exp, req, got, exp);
        end
    endtask

    task automatic expect_none(input string req);
        check(rxq.size() == 0, req, rxq.size(), 0);
        rxq.delete();
    endtask

    task automatic finish_run;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        check(serial_out === 1'b1, "R10 serial_out", serial_out, 1);
        check(fill_level === '0, "R10 fill_level", fill_level, 0);
        check(tx_empty === 1'b1 && tx_idle === 1'b1, "R10 empty/idle", {tx_empty, tx_idle}, 3);

        // R1/R2 ordering and framing, R9 idle while sending
        push_byte(8'hA5); push_byte(8'h3C); push_byte(8'h81);
        wait_start();
        check(tx_idle === 1'b0, "R9 idle low while sending", tx_idle, 0);
        wait_cyc(140);
        expect_rx(8'hA5, "R1 frame 0"); expect_rx(8'h3C, "R2 order 1"); expect_rx(8'h81, "R2 order 2");
        check(tx_idle === 1'b1 && tx_empty === 1'b1, "R9 idle after drain", {tx_idle, tx_empty}, 3);

        // R3 hold, R2 full drop, R4 bypass while disabled
        tx_disable = 1;
        for (int i = 0; i < DEPTH + 2; i++) push_byte(8'h40 + 8'(i));
        check(fill_level == LW'(DEPTH), "R2 fill at full", fill_level, DEPTH);
        check(fifo_full === 1'b1, "R2 full flag", fifo_full, 1);
        wait_cyc(100);
        expect_none("R3 disabled no data");
        pulse_flow(1'b1);
        wait_cyc(60);
        expect_rx(flow_code(1'b1), "R4 XOFF while disabled");
        check(rxq.size() == 0, "R3 only flow char", rxq.size(), 0);
        check(fill_level == LW'(DEPTH), "R3 data kept", fill_level, DEPTH);
        tx_disable = 0;
        wait_cyc(DEPTH * 40 + 60);
        for (int i = 0; i < DEPTH; i++) expect_rx(8'h40 + 8'(i), "R2 drain order");
        expect_none("R2 dropped writes not sent");

        // R3 disable raised mid-frame lets the frame finish
        push_byte(8'h11 ^ 8'hFF); push_byte(8'h22); push_byte(8'h33);
        wait_start();
        tx_disable = 1;
        wait_cyc(200);
        expect_rx(8'hEE, "R3 frame completes");
        expect_none("R3 next frame held");
        check(fill_level == 2, "R3 remaining queued", fill_level, 2);
        tx_disable = 0;
        wait_cyc(120);
        expect_rx(8'h22, "R3 resume 1"); expect_rx(8'h33, "R3 resume 2");

        // R5 flow character goes ahead of queued data
        push_byte(8'h5A); push_byte(8'h6B); push_byte(8'h7C);
        wait_start();
        pulse_flow(1'b0);
        wait_cyc(200);
        expect_rx(8'h5A, "R5 current frame");
        expect_rx(flow_code(1'b0), "R5 XON first");
        expect_rx(8'h6B, "R5 data after"); expect_rx(8'h7C, "R5 data after 2");

        // R7 DSR gating, R4 bypass with DSR
        dsr_flow_en = 1; dsr_n = 1;
        push_byte(8'hD1);
        wait_cyc(120);
        expect_none("R7 dsr blocks");
        check(fill_level == 1, "R7 byte kept", fill_level, 1);
        pulse_flow(1'b0);
        wait_cyc(60);
        expect_rx(8'h11, "R4 XON under dsr hold");
        dsr_n = 0;
        wait_cyc(60);
        expect_rx(8'hD1, "R7 dsr released");
        dsr_flow_en = 0; dsr_n = 1;
        push_byte(8'hE2);
        wait_cyc(60);
        expect_rx(8'hE2, "R7 dsr ignored when off");
        dsr_n = 0;

        // R6 xoff hold
        xoff_hold = 1;
        push_byte(8'hF3);
        wait_cyc(120);
        expect_none("R6 xoff blocks");
        xoff_hold = 0;
        wait_cyc(60);
        expect_rx(8'hF3, "R6 resume");

        // Random traffic; dsr_n toggles while gating is off (R7)
        for (int i = 0; i < 40; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            dsr_n = 1'($urandom);
            while (fifo_full) @(negedge clk);
            expq.push_back(b);
            push_byte(b);
            wait_cyc($urandom % 50);
        end
        wait_cyc(DEPTH * 40 + 100);
        foreach (expq[i]) expect_rx(expq[i], "R2 random order");
        expect_none("R2 random no extra");
        check(tx_idle === 1'b1 && serial_out === 1'b1, "R8 line marks when idle", serial_out, 1);

        finish_run();
    end
endmodule